// File: doc/BRIEF.md
# Quad Down-Counter Timer

This block has four independent decrementing counters and one shared interrupt stage, all reached through a plain word-addressed register port. A write takes effect on the clock edge where `bus_we` is high. A read returns data in the same cycle, combinationally from `bus_addr`. There is no streaming interface, so every pin is a plain control or data pin and there is no back-pressure to honour.

Each channel can run in one of three modes: periodic, free-running or one-shot. Its counter is 16 or 32 bits wide, and it advances on every clock, every 16th clock or every 256th clock. Each channel keeps two reload values. The load value is copied into the counter as soon as it is written. The background value is used only when the counter next underflows. Every underflow raises a raw interrupt bit for that channel. A mask selects which raw bits reach the masked status and the single interrupt output.

Top module: `quad_downcount_timer`

## Requirements
- R1: Shared registers are at word offsets 0x00 (mask, read/write), 0x04 (raw status, read only), 0x08 (masked status, read only) and 0x0C (clear, write only, reads zero). Channel n (0..3) occupies 0x10*(n+1) with load at +0, live value at +4, control at +8 and background value at +C. The load, control and background registers read back what was written.
- R2: A write to a channel's load register places the value into the counter at that edge, copies it into the background value, and restarts that channel's prescaler. The write takes priority over a count step in the same cycle.
- R3: A write to the background register leaves the running count untouched and is used only at the next underflow.
- R4: The control byte sets the mode: bit 7 enables, bit 6 selects periodic, bit 1 selects 32-bit width and bit 0 selects one-shot. In periodic mode (bit 6 = 1, bit 0 = 0), a step taken at zero is an underflow and reloads the background value. A load value L therefore gives L+1 steps between underflows.
- R5: In free-running mode (bit 6 = 0, bit 0 = 0), an underflow reloads the all-ones value of the selected width.
- R6: With bit 1 = 0 the counter is 16 bits wide. Values written to it lose their upper 16 bits, it wraps at 16 bits, and bits 31:16 of the live value read as zero.
- R7: In one-shot mode (bit 0 = 1, which overrides bit 6), the first step taken at zero raises one interrupt. The counter then stays at zero and raises no further interrupt until the load register is written.
- R8: Control bits 3:2 choose the step rate: 00 steps every enabled clock, 01 every 16th, and 10 or 11 every 256th. The step phase restarts at zero on any write to that channel's load or control register.
- R9: While bit 7 is 0 the counter holds its value.
- R10: An underflow sets that channel's raw status bit. Writing 1 to bit n of the clear register clears raw bit n. If an underflow and a clear hit the same bit in the same cycle, the bit stays set.
- R11: Masked status equals raw AND mask, and `irq_out` is high exactly when any masked bit is set.
- R12: After reset every register, counter and status bit is zero and `irq_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | OR of all masked interrupt bits |

## Verification
Two pairs of functions can land on the same edge. The first pair is a software clear and a hardware underflow on the same raw bit. The second is a load write and a count step on the same counter. The bench times a write to the clear register so that it lands on the exact edge of a periodic channel's underflow, then reads raw status and expects the bit still set. A plain clear two cycles later must leave the bit at zero. The load-over-step priority is checked by writing a new load value to a channel that is running at full rate and reading back the written value at the very next read.

// File: rtl/qdt_pkg.sv
package qdt_pkg;

  typedef struct packed {
    logic       en;
    logic       periodic;
    logic [1:0] rate;
    logic       wide;
    logic       oneshot;
  } qdt_ctrl_t;

  typedef enum logic [1:0] {
    CH_LOAD  = 2'd0,
    CH_VALUE = 2'd1,
    CH_CTRL  = 2'd2,
    CH_BG    = 2'd3
  } qdt_ch_reg_e;

  typedef enum logic [1:0] {
    SH_MASK  = 2'd0,
    SH_RAW   = 2'd1,
    SH_MIS   = 2'd2,
    SH_CLR   = 2'd3
  } qdt_sh_reg_e;

  function automatic qdt_ctrl_t qdt_decode(input logic [7:0] b);
    qdt_ctrl_t c;
    c.en       = b[7];
    c.periodic = b[6];
    c.rate     = b[3:2];
    c.wide     = b[1];
    c.oneshot  = b[0];
    return c;
  endfunction

endpackage

// File: rtl/qdt_prescaler.sv
module qdt_prescaler #(
  parameter int PRESC_W  = 8,
  parameter int MID_BITS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] rate,
  output logic       tick
);

  logic [PRESC_W-1:0] pcnt_q;
  logic               phase_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (restart) pcnt_q <= '0;
    else if (run)     pcnt_q <= pcnt_q + 1'b1;
  end

  always_comb begin
    unique case (rate)
      2'b00:   phase_hit = 1'b1;
      2'b01:   phase_hit = &pcnt_q[MID_BITS-1:0];
      default: phase_hit = &pcnt_q;
    endcase
  end

  assign tick = run && !restart && phase_hit;

  // R8: a restart cycle never produces a step
  a_r8_no_tick_on_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> !tick);

endmodule

// File: rtl/qdt_channel.sv
module qdt_channel
  import qdt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int PRESC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_load,
  input  logic             wr_ctrl,
  input  logic             wr_bg,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] bg_val,
  output logic [7:0]       ctrl_val,
  output logic [CNT_W-1:0] live_val,
  output logic             underflow
);

  localparam int HALF_W = CNT_W / 2;

  logic [CNT_W-1:0] cnt_q, load_q, bg_q, wmask, cnt_eff;
  logic [7:0]       ctrl_q;
  logic             done_q, tick, at_zero;
  qdt_ctrl_t        ctl;

  assign ctl     = qdt_decode(ctrl_q);
  assign wmask   = ctl.wide ? {CNT_W{1'b1}} : {{(CNT_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  assign cnt_eff = cnt_q & wmask;
  assign at_zero = (cnt_eff == '0);

  qdt_prescaler #(.PRESC_W(PRESC_W), .MID_BITS(PRESC_W/2)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctl.en),
    .restart (wr_load || wr_ctrl),
    .rate    (ctl.rate),
    .tick    (tick)
  );

  assign underflow = tick && at_zero && !wr_load && !(ctl.oneshot && done_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      load_q <= '0;
      bg_q   <= '0;
      ctrl_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata[7:0];
      if (wr_load) begin
        load_q <= wdata;
        bg_q   <= wdata;
        cnt_q  <= wdata & wmask;
        done_q <= 1'b0;
      end else begin
        if (wr_bg) bg_q <= wdata;
        if (tick) begin
          if (!at_zero)        cnt_q <= (cnt_eff - 1'b1) & wmask;
          else if (ctl.oneshot) cnt_q <= '0;
          else if (ctl.periodic) cnt_q <= bg_q & wmask;
          else                  cnt_q <= wmask;
        end
        if (underflow && ctl.oneshot) done_q <= 1'b1;
      end
    end
  end

  assign load_val = load_q;
  assign bg_val   = bg_q;
  assign ctrl_val = ctrl_q;
  assign live_val = cnt_eff;

  // R9: a disabled channel keeps its count
  a_r9_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.en && !wr_load) |=> $stable(cnt_q));

  // R7: a spent one-shot stays at zero and stays quiet
  a_r7_oneshot_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.oneshot && done_q && at_zero && !wr_load && !wr_ctrl) |=> (at_zero && !underflow));

  // R5: free-running underflow reloads all ones of the width
  a_r5_freerun_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !ctl.periodic && !ctl.oneshot) |=> (cnt_eff == wmask));

endmodule

// File: rtl/qdt_irq.sv
module qdt_irq #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] uf,
  input  logic              wr_mask,
  input  logic              wr_clr,
  input  logic [NUM_CH-1:0] wdata,
  output logic [NUM_CH-1:0] raw,
  output logic [NUM_CH-1:0] mask,
  output logic [NUM_CH-1:0] masked,
  output logic              irq
);

  logic [NUM_CH-1:0] raw_q, mask_q, clr_vec;

  assign clr_vec = wr_clr ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_vec) | uf;
      if (wr_mask) mask_q <= wdata;
    end
  end

  assign raw    = raw_q;
  assign mask   = mask_q;
  assign masked = raw_q & mask_q;
  assign irq    = |masked;

  // R10: an underflow always leaves its raw bit set, even against a clear
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|uf) |=> ((raw_q & $past(uf)) == $past(uf)));

  // R10: a clear with no competing underflow empties the bit
  a_r10_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && ((wdata & ~uf) != '0)) |=> ((raw_q & $past(wdata & ~uf)) == '0));

endmodule

// File: rtl/quad_downcount_timer.sv
module quad_downcount_timer
  import qdt_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int PRESC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);

  localparam int REGION_W = ADDR_W - 4;

  logic [REGION_W-1:0] region;
  logic [1:0]          sel;
  logic                sh_hit;
  logic [NUM_CH-1:0]   uf, raw, mask, masked;
  logic [DATA_W-1:0]   load_v [NUM_CH];
  logic [DATA_W-1:0]   bg_v   [NUM_CH];
  logic [DATA_W-1:0]   live_v [NUM_CH];
  logic [7:0]          ctrl_v [NUM_CH];

  assign region = bus_addr[ADDR_W-1:4];
  assign sel    = bus_addr[3:2];
  assign sh_hit = (region == '0);

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      logic hit;
      assign hit = (region == REGION_W'(n + 1));
      qdt_channel #(.CNT_W(DATA_W), .PRESC_W(PRESC_W)) u_ch (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_load   (bus_we && hit && sel == CH_LOAD),
        .wr_ctrl   (bus_we && hit && sel == CH_CTRL),
        .wr_bg     (bus_we && hit && sel == CH_BG),
        .wdata     (bus_wdata),
        .load_val  (load_v[n]),
        .bg_val    (bg_v[n]),
        .ctrl_val  (ctrl_v[n]),
        .live_val  (live_v[n]),
        .underflow (uf[n])
      );
    end
  endgenerate

  qdt_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .uf      (uf),
    .wr_mask (bus_we && sh_hit && sel == SH_MASK),
    .wr_clr  (bus_we && sh_hit && sel == SH_CLR),
    .wdata   (bus_wdata[NUM_CH-1:0]),
    .raw     (raw),
    .mask    (mask),
    .masked  (masked),
    .irq     (irq_out)
  );

  always_comb begin
    bus_rdata = '0;
    if (sh_hit) begin
      unique case (sel)
        SH_MASK: bus_rdata = DATA_W'(mask);
        SH_RAW:  bus_rdata = DATA_W'(raw);
        SH_MIS:  bus_rdata = DATA_W'(masked);
        default: bus_rdata = '0;
      endcase
    end
    for (int n = 0; n < NUM_CH; n++) begin
      if (region == REGION_W'(n + 1)) begin
        unique case (sel)
          CH_LOAD:  bus_rdata = load_v[n];
          CH_VALUE: bus_rdata = live_v[n];
          CH_CTRL:  bus_rdata = DATA_W'(ctrl_v[n]);
          default:  bus_rdata = bg_v[n];
        endcase
      end
    end
  end

  // R11: the interrupt pin follows the masked status
  a_r11_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((raw & mask) != '0));

endmodule

// File: tb/quad_downcount_timer_tb.sv
`timescale 1ns/1ps
module quad_downcount_timer_tb;

  typedef struct {
    logic [7:0]  addr;
    logic [31:0] exp;
    bit          pin;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  bit    finished = 1'b0;
  item_t exp_q[$];

  always #10 clk = ~clk;

  quad_downcount_timer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
  );

  // monitor: pops expectations and compares away from the rising edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = exp_q.pop_front();
      act = it.pin ? {31'd0, irq_out} : bus_rdata;
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s addr=0x%02h actual=0x%08h expected=0x%08h", it.tag, it.addr, act, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog (all requirements): cycles=%0d expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #2;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    bus_addr = a;
    it.addr = a; it.exp = e; it.pin = 1'b0; it.tag = tag;
    exp_q.push_back(it);
    @(posedge clk); #2;
  endtask

  task automatic pin(input logic e, input string tag);
    item_t it;
    it.addr = 8'hFF; it.exp = {31'd0, e}; it.pin = 1'b1; it.tag = tag;
    exp_q.push_back(it);
    @(posedge clk); #2;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic quiet();
    for (int n = 1; n <= 4; n++) wr(8'(n * 16 + 8), 32'h0);
    wr(8'h0C, 32'hF);
    wr(8'h00, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R12 reset state
    rd(8'h00, 0, "R12 mask");
    rd(8'h04, 0, "R12 raw");
    rd(8'h14, 0, "R12 ch0 value");
    rd(8'h18, 0, "R12 ch0 ctrl");
    pin(1'b0, "R12 irq");

    // R6/R1/R2: 16-bit load drops upper bits; registers read back
    wr(8'h10, 32'h0001_2345);
    rd(8'h14, 32'h0000_2345, "R6 16-bit value");
    rd(8'h10, 32'h0001_2345, "R1 load readback");
    rd(8'h1C, 32'h0001_2345, "R2 bg copied by load");
    wr(8'h18, 32'h02);
    rd(8'h18, 32'h02, "R1 ctrl readback");
    idle(5);
    rd(8'h14, 32'h0000_2345, "R9 disabled holds");
    rd(8'h0C, 0, "R1 clear reads zero");

    // R4 periodic at full rate, R11 mask
    wr(8'h10, 32'd5);
    wr(8'h18, 32'hC2);
    rd(8'h14, 5, "R4 value after enable");
    rd(8'h14, 4, "R4 first step");
    idle(3);
    rd(8'h04, 0, "R4 no underflow before L+1 steps");
    rd(8'h04, 1, "R10 raw set on underflow");
    rd(8'h14, 4, "R4 reloaded then stepped");
    rd(8'h08, 0, "R11 masked off");
    pin(1'b0, "R11 irq low while masked");
    wr(8'h00, 32'h1);
    rd(8'h08, 1, "R11 masked on");
    pin(1'b1, "R11 irq high");
    quiet();

    // R3 background value applied only at underflow; R2 load while running
    wr(8'h20, 32'd3);
    wr(8'h28, 32'hC2);
    wr(8'h2C, 32'd10);
    rd(8'h24, 2, "R3 bg write leaves count");
    idle(1);
    rd(8'h24, 0, "R3 count reached zero");
    rd(8'h24, 10, "R3 reload from new bg");
    rd(8'h04, 2, "R10 ch1 raw");
    wr(8'h20, 32'd100);
    rd(8'h24, 100, "R2 load wins over step");
    quiet();

    // R5/R6 free-running 16-bit
    wr(8'h30, 32'd2);
    wr(8'h38, 32'h80);
    rd(8'h34, 2, "R5 start");
    idle(1);
    rd(8'h34, 0, "R5 at zero");
    rd(8'h34, 32'h0000_FFFF, "R5 R6 reload 16-bit all ones");
    rd(8'h04, 4, "R10 ch2 raw");
    quiet();

    // R7 one-shot (bit 0 overrides periodic)
    wr(8'h40, 32'd1);
    wr(8'h48, 32'hC3);
    rd(8'h44, 1, "R7 start");
    rd(8'h44, 0, "R7 at zero");
    rd(8'h04, 8, "R7 single interrupt");
    wr(8'h0C, 32'h8);
    idle(20);
    rd(8'h04, 0, "R7 no second interrupt");
    rd(8'h44, 0, "R7 stays zero");
    wr(8'h40, 32'd2);
    idle(5);
    rd(8'h04, 8, "R7 rearmed by load");
    quiet();

    // R8 prescaler divide by 16 and 256
    wr(8'h20, 32'd1);
    wr(8'h28, 32'h86);
    idle(31);
    rd(8'h04, 0, "R8 div16 before 32 clocks");
    rd(8'h04, 2, "R8 div16 at 32 clocks");
    quiet();
    wr(8'h20, 32'd0);
    wr(8'h28, 32'h8A);
    idle(255);
    rd(8'h04, 0, "R8 div256 before 256 clocks");
    rd(8'h04, 2, "R8 div256 at 256 clocks");
    quiet();

    // R10 clear and underflow on the same edge
    wr(8'h10, 32'd3);
    wr(8'h18, 32'hC2);
    idle(7);
    wr(8'h0C, 32'h1);
    rd(8'h04, 1, "R10 set wins over clear");
    wr(8'h0C, 32'h1);
    rd(8'h04, 0, "R10 plain clear");

    idle(2);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule